// File: doc/BRIEF.md
# Thermal Trip Emergency Shutdown Monitor

This block watches an active-low overheat warning driven by the processor and, once a trip is qualified, forces the three sleep-control outputs (S3, S4, S5 rails) low at once. It needs no handshake from any other power-management logic. A short low glitch on the warning line is rejected by a consecutive-sample filter. The filter requires the line to stay low for at least 25 ns, sized in clock cycles from the clock-period parameter.

The input is only honoured inside a monitoring window. A select input picks the event that opens the window: the platform reset being released, or the processor power-good rising. The window always closes when processor power-good falls. A qualified trip latches. The sleep outputs stay low and a sticky prepare-to-sleep status stays set until the power-cycle reset. A single-cycle strobe clears the power button status elsewhere in the chip.

Top module: `thermtrip_guard`

## Requirements
- R1: While `pwr_rst_n` is low, `slp3_n`, `slp4_n` and `slp5_n` are 1, and `prep_sts` and `pbtn_sts_clr` are 0.
- R2: A low run on `trip_n_raw` lasting fewer than FILT_CYC consecutive sampled cycles never trips. FILT_CYC is ceil(25000 / CLK_PERIOD_PS), which is 3 at 100 MHz.
- R3: While monitoring is open, a low run of FILT_CYC consecutive sampled cycles trips the block. The outputs fall after the (SYNC_STAGES + FILT_CYC)-th rising edge, counting the first edge that samples the input low. That is 5 cycles at the defaults, well inside 1 µs.
- R4: With `valid_sel` = 0, monitoring opens on the clock after `plat_rst_n` is sampled rising (0 then 1) while `cpu_pwrgd` is 1. A rise of `cpu_pwrgd` alone does not open it.
- R5: With `valid_sel` = 1, monitoring opens on the clock after `cpu_pwrgd` is sampled rising. A rise of `plat_rst_n` alone does not open it.
- R6: Monitoring closes on the clock after `cpu_pwrgd` is sampled 0, under either `valid_sel` setting. A low run that reaches the filter while monitoring is closed has no effect, and the run count restarts.
- R7: After a trip, the three sleep outputs stay 0 and `prep_sts` stays 1 whatever the other inputs do, until `pwr_rst_n` is asserted.
- R8: `pbtn_sts_clr` is 1 for exactly one cycle per trip, in the same cycle in which the sleep outputs first read 0.
- R9: The three sleep outputs always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| pwr_rst_n | input | 1 | Power-cycle reset, asynchronous, active low |
| trip_n_raw | input | 1 | Raw processor overheat warning, active low, asynchronous |
| valid_sel | input | 1 | Window start select: 0 = platform reset release, 1 = power-good rise |
| plat_rst_n | input | 1 | Platform reset, active low, synchronous to clk |
| cpu_pwrgd | input | 1 | Processor power-good, synchronous to clk |
| slp3_n | output | 1 | S3 sleep control, driven low on trip |
| slp4_n | output | 1 | S4 sleep control, driven low on trip |
| slp5_n | output | 1 | S5 sleep control, driven low on trip |
| prep_sts | output | 1 | Sticky prepare-to-sleep status |
| pbtn_sts_clr | output | 1 | One-cycle strobe clearing power button status |

## Verification
A wrong glitch-run count shows at the sleep outputs. A filter that is too short drops them on a two-cycle pulse, and one that is too long moves the fall by one cycle or more from the expected edge. A wrong monitoring window shows as a missing trip, or as a trip taken while power-good is low or after the wrong start event. Because the reference model is compared on every clock, any of these is reported in the cycle the outputs first disagree. A strobe or status fault is caught in the same cycle the trip takes effect.

// File: rtl/thermtrip_guard.sv
module thermtrip_guard #(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int GLITCH_PS     = 25000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic pwr_rst_n,
  input  logic trip_n_raw,
  input  logic valid_sel,
  input  logic plat_rst_n,
  input  logic cpu_pwrgd,
  output logic slp3_n,
  output logic slp4_n,
  output logic slp5_n,
  output logic prep_sts,
  output logic pbtn_sts_clr
);
  localparam int FILT_RAW = (GLITCH_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int FILT_CYC = (FILT_RAW < 1) ? 1 : FILT_RAW;
  localparam int CW       = $clog2(FILT_CYC + 1);

  logic          trip_low;
  logic          plat_q, pg_q, armed, tripped, qualify;
  logic [CW-1:0] low_cnt;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge pwr_rst_n)
        if (!pwr_rst_n) s_q <= 1'b1;
        else            s_q <= trip_n_raw;
      assign trip_low = ~s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge pwr_rst_n)
        if (!pwr_rst_n) s_q <= '1;
        else            s_q <= {s_q[SYNC_STAGES-2:0], trip_n_raw};
      assign trip_low = ~s_q[SYNC_STAGES-1];
    end
  endgenerate

  wire start_evt = valid_sel ? (cpu_pwrgd & ~pg_q) : (plat_rst_n & ~plat_q);
  wire hit       = armed & trip_low & ~tripped;
  assign qualify = hit & (low_cnt == CW'(FILT_CYC - 1));

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      plat_q       <= 1'b0;
      pg_q         <= 1'b0;
      armed        <= 1'b0;
      low_cnt      <= '0;
      tripped      <= 1'b0;
      prep_sts     <= 1'b0;
      pbtn_sts_clr <= 1'b0;
    end else begin
      plat_q       <= plat_rst_n;
      pg_q         <= cpu_pwrgd;
      armed        <= cpu_pwrgd & (armed | start_evt);
      low_cnt      <= (hit & ~qualify) ? low_cnt + 1'b1 : '0;
      tripped      <= tripped | qualify;
      prep_sts     <= prep_sts | qualify;
      pbtn_sts_clr <= qualify;
    end
  end

  assign slp3_n = ~tripped;
  assign slp4_n = ~tripped;
  assign slp5_n = ~tripped;
endmodule

// File: rtl/thermtrip_guard_chk.sv
module thermtrip_guard_chk (
  input logic clk,
  input logic pwr_rst_n,
  input logic trip_n_raw,
  input logic cpu_pwrgd,
  input logic slp3_n,
  input logic slp4_n,
  input logic slp5_n,
  input logic prep_sts,
  input logic pbtn_sts_clr
);
  // R1
  always @(posedge clk)
    if (!pwr_rst_n)
      reset_idle_chk: assert (slp3_n && slp4_n && slp5_n && !prep_sts && !pbtn_sts_clr);

  // R7
  trip_hold_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !slp5_n |=> !slp5_n && prep_sts);

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    pbtn_sts_clr |=> !pbtn_sts_clr);

  // R8
  strobe_on_fall_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    $fell(slp3_n) |-> pbtn_sts_clr);

  // R6
  powered_trip_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    $fell(slp4_n) |-> $past(cpu_pwrgd, 2));

  // R3
  input_low_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    $fell(slp5_n) |-> !$past(trip_n_raw, 3));

  // R9
  rails_agree_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (slp3_n == slp4_n) && (slp4_n == slp5_n));
endmodule

bind thermtrip_guard thermtrip_guard_chk u_chk (
  .clk(clk), .pwr_rst_n(pwr_rst_n), .trip_n_raw(trip_n_raw), .cpu_pwrgd(cpu_pwrgd),
  .slp3_n(slp3_n), .slp4_n(slp4_n), .slp5_n(slp5_n),
  .prep_sts(prep_sts), .pbtn_sts_clr(pbtn_sts_clr)
);

// File: tb/sim_thermtrip_guard.sv
`timescale 1ns/1ps
module sim_thermtrip_guard;
  localparam int PERIOD_PS = 10000;
  localparam int FILT = (25000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int SYNC = 2;

  logic clk = 0, pwr_rst_n = 0, trip_n_raw = 1, valid_sel = 0, plat_rst_n = 0, cpu_pwrgd = 0;
  logic slp3_n, slp4_n, slp5_n, prep_sts, pbtn_sts_clr;
  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  thermtrip_guard #(.CLK_PERIOD_PS(PERIOD_PS), .GLITCH_PS(25000), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .trip_n_raw(trip_n_raw), .valid_sel(valid_sel),
    .plat_rst_n(plat_rst_n), .cpu_pwrgd(cpu_pwrgd), .slp3_n(slp3_n), .slp4_n(slp4_n),
    .slp5_n(slp5_n), .prep_sts(prep_sts), .pbtn_sts_clr(pbtn_sts_clr));

  always #5 clk = ~clk;

  bit q_in[$];
  bit m_mon, m_trip, m_strobe, m_prev_pr, m_prev_pg;
  int m_run;

  always @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      q_in.delete();
      for (int i = 0; i < SYNC; i++) q_in.push_back(1'b1);
      m_mon = 0; m_trip = 0; m_strobe = 0; m_run = 0; m_prev_pr = 0; m_prev_pg = 0;
    end else begin
      bit seen_low, open_evt, next_mon;
      seen_low = !q_in.pop_front();
      q_in.push_back(trip_n_raw);
      open_evt = valid_sel ? (cpu_pwrgd && !m_prev_pg) : (plat_rst_n && !m_prev_pr);
      next_mon = cpu_pwrgd && (m_mon || open_evt);
      m_strobe = 0;
      if (!m_trip && m_mon && seen_low) begin
        m_run++;
        if (m_run >= FILT) begin m_trip = 1; m_strobe = 1; m_run = 0; end
      end else m_run = 0;
      m_mon = next_mon;
      m_prev_pr = plat_rst_n;
      m_prev_pg = cpu_pwrgd;
    end
  end

  task automatic check1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    check1(cur_req, "slp3_n", slp3_n, !m_trip);
    check1("R9", "slp4_n", slp4_n, !m_trip);
    check1("R9", "slp5_n", slp5_n, !m_trip);
    check1(cur_req, "prep_sts", prep_sts, m_trip);
    check1("R8", "pbtn_sts_clr", pbtn_sts_clr, m_strobe);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic low_pulse(int n);
    @(negedge clk) trip_n_raw = 0;
    repeat (n - 1) @(negedge clk);
    @(negedge clk) trip_n_raw = 1;
  endtask

  task automatic power_reset();
    @(negedge clk) pwr_rst_n = 0;
    idle(2);
    check1("R1", "reset slp5_n", slp5_n, 1'b1);
    check1("R1", "reset prep_sts", prep_sts, 1'b0);
    check1("R1", "reset pbtn_sts_clr", pbtn_sts_clr, 1'b0);
    pwr_rst_n = 1;
  endtask

  initial begin
    idle(3);
    check1("R1", "reset slp3_n", slp3_n, 1'b1);
    check1("R1", "reset prep_sts", prep_sts, 1'b0);
    @(negedge clk) pwr_rst_n = 1;

    cur_req = "R6";
    plat_rst_n = 1; idle(2);
    low_pulse(10); idle(6);
    check1("R6", "unpowered trip ignored", slp5_n, 1'b1);

    cur_req = "R4";
    @(negedge clk) plat_rst_n = 0; cpu_pwrgd = 1;
    idle(2);
    low_pulse(8); idle(6);
    check1("R4", "power-good rise alone ignored", slp5_n, 1'b1);
    @(negedge clk) plat_rst_n = 1;
    idle(3);

    cur_req = "R2";
    low_pulse(1); idle(5);
    low_pulse(FILT - 1); idle(6);
    check1("R2", "glitch ignored", slp5_n, 1'b1);

    cur_req = "R3";
    low_pulse(FILT);
    idle(1);
    check1("R3", "not yet tripped", slp5_n, 1'b1);
    idle(5);
    check1("R3", "tripped", slp5_n, 1'b0);

    cur_req = "R7";
    @(negedge clk) cpu_pwrgd = 0; plat_rst_n = 0; valid_sel = 1;
    idle(3);
    @(negedge clk) cpu_pwrgd = 1; plat_rst_n = 1;
    low_pulse(6); idle(4);
    check1("R7", "latched low", slp4_n, 1'b0);
    check1("R7", "status held", prep_sts, 1'b1);

    cur_req = "R5";
    valid_sel = 0; cpu_pwrgd = 0; plat_rst_n = 0;
    power_reset();
    @(negedge clk) cpu_pwrgd = 1;
    idle(2);
    @(negedge clk) valid_sel = 1;
    idle(1);
    @(negedge clk) plat_rst_n = 1;
    idle(2);
    low_pulse(8); idle(6);
    check1("R5", "platform reset release ignored", slp5_n, 1'b1);
    @(negedge clk) cpu_pwrgd = 0;
    idle(2);
    @(negedge clk) cpu_pwrgd = 1;
    idle(2);

    cur_req = "R6";
    @(negedge clk) trip_n_raw = 0;
    idle(1);
    @(negedge clk) cpu_pwrgd = 0;
    idle(2);
    @(negedge clk) trip_n_raw = 1;
    idle(6);
    check1("R6", "window closed mid-run", slp5_n, 1'b1);

    cur_req = "R5";
    @(negedge clk) cpu_pwrgd = 1;
    idle(2);
    low_pulse(FILT + 2); idle(6);
    check1("R5", "power-good window trip", slp3_n, 1'b0);
    check1("R5", "status set", prep_sts, 1'b1);

    cur_req = "R1";
    power_reset();
    idle(3);
    check1("R1", "cleared after power reset", slp3_n, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule